// File: doc/BRIEF.md
# Serial Tuning-Word Loader for a Direct Digital Synthesizer

This block is the write-only front end of a direct digital synthesizer. A host shifts 16-bit words into it over three wires: a serial clock, an active-low frame strobe and a data line. Each word carries a 2-bit register address in its top bits. The block decodes that address and updates one of five registers: a 16-bit control word, two 28-bit frequency tuning words and two 12-bit phase offsets. Its outputs drive the synthesis datapath directly.

A frequency tuning word is 28 bits wide, but a serial word holds only 14 payload bits. A control bit picks between two ways to load it. In paired mode, two writes to the same frequency register deliver the lower half and then the upper half, and the 28-bit register changes in a single cycle. In half mode, each write replaces either the upper or the lower 14 bits, and the other half keeps its value.

The serial pins are asynchronous to the system clock. They are brought into the system clock domain by a synchronizer, and all register updates happen on the system clock.

Top module: `dds_reg_loader`

## Requirements
- R1: Serial data is taken MSB first, one bit on each falling edge of the serial clock while the frame strobe is low. After the 16th bit, the completed word is applied to the registers.
- R2: If the frame strobe rises before 16 bits have been taken, the partial word is dropped and no register changes.
- R3: Once 16 bits have been taken, further serial clock edges in the same frame are ignored until the strobe goes high.
- R4: Bits [15:14] of a word are the address: 00 selects the control word, 01 selects frequency register 0 and 10 selects frequency register 1. Address 11 is a phase write. Bit 13 picks phase register 0 or 1, bits [11:0] are the new value, and no frequency or control state changes.
- R5: With control bit 13 set (paired mode), the first frequency write is held aside and the target register does not change. A second write to the same register loads bits [27:14] from the second word and bits [13:0] from the first word, both in one update.
- R6: With control bit 13 clear (half mode), a frequency write replaces bits [27:14] when control bit 12 is 1 and bits [13:0] when it is 0. The other half is unchanged.
- R7: In paired mode, a frequency write to the other register while a half is held discards the held half and starts a new pair. A control write also discards the held half.
- R8: The flag outputs follow the control word: frequency select is bit 11, phase select is bit 10, core reset is bit 8 and sleep is bits [7:6].
- R9: After reset, every register and flag is zero and no half is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| fsync_ni | input | 1 | Frame strobe, active low |
| sdata_i | input | 1 | Serial data, MSB first |
| ctrl_o | output | 16 | Control word |
| freq0_o | output | 28 | Frequency tuning word 0 |
| freq1_o | output | 28 | Frequency tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| freq_sel_o | output | 1 | Selects the active frequency register |
| phase_sel_o | output | 1 | Selects the active phase register |
| core_rst_o | output | 1 | Holds the synthesis core in reset |
| sleep_o | output | 2 | Power-down controls |

## Verification
The bench builds the block with its default parameters: 16-bit words, 28-bit frequency registers, 12-bit phase registers and a two-stage synchronizer. Each serial clock phase lasts three system clocks, which is close to the fastest rate the synchronizer can follow. At that rate every falling edge must be caught as it arrives. This setting also exercises frame strobes that end a word early or extend it with extra clocks. The bench covers paired loads that complete, paired loads that restart on another register, and paired loads abandoned by a mode change. It also covers upper-half and lower-half updates, and phase writes, which must leave the tuning words untouched.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned HALF_W = WORD_W - 2;
  localparam int unsigned FREQ_W = 2 * HALF_W;
  localparam int unsigned PH_W   = 12;
  localparam int unsigned N_FREQ = 2;
  localparam int unsigned N_PH   = 2;
  // control word bit positions
  localparam int unsigned CB_PAIR = 13;
  localparam int unsigned CB_HALF = 12;
  localparam int unsigned CB_FSEL = 11;
  localparam int unsigned CB_PSEL = 10;
  localparam int unsigned CB_RST  = 8;
  localparam int unsigned CB_SLP  = 6;
  typedef enum logic [1:0] {
    A_CTRL = 2'b00,
    A_F0   = 2'b01,
    A_F1   = 2'b10,
    A_PH   = 2'b11
  } addr_e;
endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= rst_val_i;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ldr_shift.sv
module ldr_shift
  import dds_ldr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_ni,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic             sclk_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic             vld_q;
  logic             fall;

  assign fall = sclk_prev_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
      vld_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      vld_q       <= 1'b0;
      if (fsync_ni) begin
        cnt_q <= '0;
      end else if (fall && cnt_q < CNT_FULL) begin
        sr_q  <= {sr_q[WORD_W-2:0], sdata_i};
        cnt_q <= cnt_q + 1'b1;
        vld_q <= (cnt_q == CNT_LAST);
      end
    end
  end

  assign word_o     = sr_q;
  assign word_vld_o = vld_q;

  AST_VLD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(!fsync_ni)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_FULL && !fsync_ni) |=> $stable(sr_q) && !word_vld_o); // R3
endmodule

// File: rtl/ldr_bank.sv
module ldr_bank
  import dds_ldr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [FREQ_W-1:0] freq0_o,
  output logic [FREQ_W-1:0] freq1_o,
  output logic [PH_W-1:0]   phase0_o,
  output logic [PH_W-1:0]   phase1_o
);
  logic [WORD_W-1:0] ctrl_q;
  logic [FREQ_W-1:0] freq_q  [N_FREQ];
  logic [PH_W-1:0]   phase_q [N_PH];
  logic              pend_q;
  logic              pidx_q;
  logic [HALF_W-1:0] plo_q;

  addr_e             addr;
  logic [HALF_W-1:0] dat;
  logic              tgt;

  assign addr = addr_e'(word_i[WORD_W-1 -: 2]);
  assign dat  = word_i[HALF_W-1:0];
  assign tgt  = word_i[WORD_W-1];  // 01 -> reg 0, 10 -> reg 1

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      pidx_q <= 1'b0;
      plo_q  <= '0;
      for (int i = 0; i < N_FREQ; i++) freq_q[i] <= '0;
      for (int i = 0; i < N_PH; i++) phase_q[i] <= '0;
    end else if (word_vld_i) begin
      unique case (addr)
        A_CTRL: begin
          ctrl_q <= word_i;
          pend_q <= 1'b0;
        end
        A_F0, A_F1: begin
          if (ctrl_q[CB_PAIR]) begin
            if (pend_q && pidx_q == tgt) begin
              freq_q[tgt] <= {dat, plo_q};
              pend_q      <= 1'b0;
            end else begin
              plo_q  <= dat;
              pidx_q <= tgt;
              pend_q <= 1'b1;
            end
          end else if (ctrl_q[CB_HALF]) begin
            freq_q[tgt][FREQ_W-1 -: HALF_W] <= dat;
          end else begin
            freq_q[tgt][HALF_W-1:0] <= dat;
          end
        end
        default: phase_q[word_i[HALF_W-1]] <= word_i[PH_W-1:0];
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign freq0_o  = freq_q[0];
  assign freq1_o  = freq_q[1];
  assign phase0_o = phase_q[0];
  assign phase1_o = phase_q[1];

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> $stable(ctrl_o) && $stable(freq0_o) && $stable(freq1_o)
                    && $stable(phase0_o) && $stable(phase1_o)); // R2
  AST_PHASE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && addr == A_PH) |=> $stable(ctrl_o) && $stable(freq0_o)
                                     && $stable(freq1_o)); // R4
  AST_PAIR_FIRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && (addr == A_F0 || addr == A_F1) && ctrl_o[CB_PAIR]
     && !(pend_q && pidx_q == tgt)) |=> $stable(freq0_o) && $stable(freq1_o)); // R5
  AST_HALF_KEEP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && (addr == A_F0 || addr == A_F1) && !ctrl_o[CB_PAIR] && ctrl_o[CB_HALF])
    |=> $stable(freq0_o[HALF_W-1:0]) && $stable(freq1_o[HALF_W-1:0])); // R6
  AST_HALF_KEEP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && (addr == A_F0 || addr == A_F1) && !ctrl_o[CB_PAIR] && !ctrl_o[CB_HALF])
    |=> $stable(freq0_o[FREQ_W-1:HALF_W]) && $stable(freq1_o[FREQ_W-1:HALF_W])); // R6
endmodule

// File: rtl/dds_reg_loader.sv
module dds_reg_loader
  import dds_ldr_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_ni,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [FREQ_W-1:0] freq0_o,
  output logic [FREQ_W-1:0] freq1_o,
  output logic [PH_W-1:0]   phase0_o,
  output logic [PH_W-1:0]   phase1_o,
  output logic              freq_sel_o,
  output logic              phase_sel_o,
  output logic              core_rst_o,
  output logic [1:0]        sleep_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  ldr_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       ({sclk_i, fsync_ni, sdata_i}),
    .rst_val_i (3'b110),
    .q_o       (pins_s)
  );

  ldr_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (pins_s[2]),
    .fsync_ni   (pins_s[1]),
    .sdata_i    (pins_s[0]),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  ldr_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .word_vld_i (word_vld),
    .ctrl_o     (ctrl_o),
    .freq0_o    (freq0_o),
    .freq1_o    (freq1_o),
    .phase0_o   (phase0_o),
    .phase1_o   (phase1_o)
  );

  assign freq_sel_o  = ctrl_o[CB_FSEL];
  assign phase_sel_o = ctrl_o[CB_PSEL];
  assign core_rst_o  = ctrl_o[CB_RST];
  assign sleep_o     = ctrl_o[CB_SLP +: 2];
endmodule

// File: tb/dds_reg_loader_bench.sv
module dds_reg_loader_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b1;
  logic fsync_ni = 1'b1;
  logic sdata_i = 1'b0;
  logic [15:0] ctrl_o;
  logic [27:0] freq0_o, freq1_o;
  logic [11:0] phase0_o, phase1_o;
  logic freq_sel_o, phase_sel_o, core_rst_o;
  logic [1:0] sleep_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dds_reg_loader u_dds_reg_loader (
    .clk_i, .rst_ni, .sclk_i, .fsync_ni, .sdata_i,
    .ctrl_o, .freq0_o, .freq1_o, .phase0_o, .phase1_o,
    .freq_sel_o, .phase_sel_o, .core_rst_o, .sleep_o
  );

  typedef struct {
    string       tag;
    logic [15:0] ctrl;
    logic [27:0] f0, f1;
    logic [11:0] p0, p1;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int req_cnt = 0, seen_cnt = 0;

  // reference model state
  logic [15:0] m_ctrl = '0;
  logic [27:0] m_f0 = '0, m_f1 = '0;
  logic [11:0] m_p0 = '0, m_p1 = '0;
  logic        m_pend = 1'b0, m_pidx = 1'b0;
  logic [13:0] m_plo = '0;

  localparam int HALF = 3;

  task automatic model(input logic [15:0] w);
    logic [13:0] d = w[13:0];
    logic t = w[15];
    case (w[15:14])
      2'b00: begin m_ctrl = w; m_pend = 1'b0; end
      2'b11: if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
      default: begin
        if (m_ctrl[13]) begin
          if (m_pend && m_pidx == t) begin
            if (t) m_f1 = {d, m_plo}; else m_f0 = {d, m_plo};
            m_pend = 1'b0;
          end else begin
            m_plo = d; m_pidx = t; m_pend = 1'b1;
          end
        end else if (m_ctrl[12]) begin
          if (t) m_f1[27:14] = d; else m_f0[27:14] = d;
        end else begin
          if (t) m_f1[13:0] = d; else m_f0[13:0] = d;
        end
      end
    endcase
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra);
    @(negedge clk_i);
    fsync_ni = 1'b0;
    repeat (HALF) @(negedge clk_i);
    for (int i = 0; i < nbits + extra; i++) begin
      sdata_i = (i < nbits) ? w[15-i] : 1'b1;
      repeat (HALF) @(negedge clk_i);
      sclk_i = 1'b0;
      repeat (HALF) @(negedge clk_i);
      sclk_i = 1'b1;
    end
    repeat (HALF) @(negedge clk_i);
    fsync_ni = 1'b1;
    if (nbits == 16) model(w);
    repeat (10) @(negedge clk_i);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.tag = tag; e.ctrl = m_ctrl; e.f0 = m_f0; e.f1 = m_f1; e.p0 = m_p0; e.p1 = m_p1;
    exp_q.push_back(e);
    req_cnt++;
    wait (seen_cnt == req_cnt);
  endtask

  task automatic cmp(input string tag, input string what, input logic [27:0] act,
                     input logic [27:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations and compares against outputs
  initial begin
    forever begin
      exp_t e;
      wait (req_cnt != seen_cnt);
      @(negedge clk_i);
      e = exp_q.pop_front();
      cmp(e.tag, "ctrl", 28'(ctrl_o), 28'(e.ctrl));
      cmp(e.tag, "freq0", freq0_o, e.f0);
      cmp(e.tag, "freq1", freq1_o, e.f1);
      cmp(e.tag, "phase0", 28'(phase0_o), 28'(e.p0));
      cmp(e.tag, "phase1", 28'(phase1_o), 28'(e.p1));
      cmp({e.tag, "/R8"}, "fsel", 28'(freq_sel_o), 28'(e.ctrl[11]));
      cmp({e.tag, "/R8"}, "psel", 28'(phase_sel_o), 28'(e.ctrl[10]));
      cmp({e.tag, "/R8"}, "crst", 28'(core_rst_o), 28'(e.ctrl[8]));
      cmp({e.tag, "/R8"}, "sleep", 28'(sleep_o), 28'(e.ctrl[7:6]));
      seen_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    expect_now("R9 reset");

    frame(16'h2D40, 16, 0);               expect_now("R1 ctrl pair+flags");
    frame(16'h4000 | 16'h1234, 16, 0);    expect_now("R5 first half held");
    frame(16'h4000 | 16'h2ABC, 16, 0);    expect_now("R5 pair commit f0");
    frame(16'h8000 | 16'h0111, 16, 0);    expect_now("R7 f1 first");
    frame(16'h4000 | 16'h0222, 16, 0);    expect_now("R7 restart on f0");
    frame(16'h4000 | 16'h3FFF, 16, 0);    expect_now("R7 f0 commit");
    frame(16'h8000 | 16'h0AAA, 16, 0);    expect_now("R7 f1 held");
    frame(16'h20C0, 16, 0);               expect_now("R7 ctrl drops held");
    frame(16'h8000 | 16'h0555, 16, 0);    expect_now("R7 new first after ctrl");
    frame(16'h1000, 16, 0);               expect_now("R6 half upper mode");
    frame(16'h8000 | 16'h1555, 16, 0);    expect_now("R6 f1 upper");
    frame(16'h4000 | 16'h0F0F, 16, 0);    expect_now("R6 f0 upper");
    frame(16'h0100, 16, 0);               expect_now("R6 half lower mode");
    frame(16'h8000 | 16'h2AAA, 16, 0);    expect_now("R6 f1 lower");
    frame(16'hC000 | 16'h0ABC, 16, 0);    expect_now("R4 phase0");
    frame(16'hE000 | 16'h0123, 16, 0);    expect_now("R4 phase1");
    frame(16'hCFFF, 10, 0);               expect_now("R2 partial dropped");
    frame(16'h0000, 15, 0);               expect_now("R2 fifteen bits dropped");
    frame(16'hE000 | 16'h0456, 16, 5);    expect_now("R3 extra clocks ignored");
    frame(16'h0E00, 16, 0);               expect_now("R8 flags only");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule